// File: doc/BRIEF.md
# Sync-Tip Gain and Black-Level Control Loop

This block closes a digital control loop around an external video amplifier and 8-bit converter. Each converted sample enters as a stream beat. Two window pulses frame each line. The gain window covers the horizontal sync tip. When it closes, the block nudges a gain code so that the lowest sample seen in the window settles at code 0. The clamp window covers the back porch. When it closes, the block nudges an offset code so that the porch average moves onto a programmable reference level. Both codes are registered outputs that drive the analog side.

A white-peak limiter can be switched on with `wpe_en`. While it is on, any accepted sample above code 248 marks the current line as overdriven. At the next gain-window close the gain code then steps down, whatever the sync-tip measurement asks for. With the limiter off, bright content may run up to code 255 and only the sync tip regulates the gain.

The sample input is a valid/ready stream whose ready is held high at all times. The block never applies back-pressure. A beat counts only in a cycle where `s_valid` is high, and a source may insert idle cycles anywhere, including inside a window.

Top module: `agc_sync_tip`

## Requirements
- R1: While `rst_n` is low, and after it is released, both `gain_code` and `offset_code` hold mid-scale (128) until a window close changes them.
- R2: `s_ready` is always 1. A cycle with `s_valid` low contributes nothing to any measurement, whatever `s_data` holds.
- R3: When the gain window closes and the smallest accepted sample inside it was above 0, `gain_code` rises by one. The change appears on the clock edge at which `gain_win` is first sampled low.
- R4: When the gain window closes and every accepted sample inside it was 0, `gain_code` falls by one. If the smallest sample was 0 but some other sample was not, `gain_code` holds.
- R5: With `wpe_en` high, an accepted sample above 248 anywhere since the previous gain-window close makes the next close lower `gain_code` by one. This overrides the R3 increment.
- R6: A sample of exactly 248, or any sample accepted while `wpe_en` is low, has no white-peak effect.
- R7: `gain_code` saturates at 0 and 255 and never wraps.
- R8: When the clamp window closes, the first 8 accepted samples of that window are averaged (sum shifted right by 3). Samples after the eighth are ignored. If the average is above `clamp_ref`, `offset_code` falls by one. If it is below, `offset_code` rises by one. If it is equal, or fewer than 8 samples arrived, `offset_code` holds.
- R9: `offset_code` saturates at 0 and 255 and never wraps.
- R10: Each code changes by at most one step, and only on the edge that closes its own window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample beat valid |
| s_ready | output | 1 | Always high; the block accepts every beat |
| s_data | input | 8 | Converted video sample |
| gain_win | input | 1 | High across the sync-tip measurement window |
| clamp_win | input | 1 | High across the back-porch window |
| wpe_en | input | 1 | Enables the white-peak gain limiter |
| clamp_ref | input | 8 | Target back-porch level |
| gain_code | output | 8 | Amplifier gain control code |
| offset_code | output | 8 | DC offset control code |

## Verification
A corrupted minimum tracker, zero flag or peak flag shows up as a wrong gain step on the very next gain-window close. A line-by-line comparison therefore isolates the fault to a single line. A bad accumulator or sample counter gives a wrong or missing offset step at the next clamp-window close. A saturation or wrap error appears only after the code has been driven to an end stop, so long one-directional runs push each code into both rails.

// File: rtl/agc_pkg.sv
package agc_pkg;

  // Direction requested from a control code register for one line.
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

endpackage

// File: rtl/agc_step_reg.sv
// Saturating up/down control code register.
module agc_step_reg
  import agc_pkg::*;
#(
  parameter int W   = 8,
  parameter int RST = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  step_e        step,
  output logic [W-1:0] code
);

  localparam logic [W-1:0] TOP  = {W{1'b1}};
  localparam logic [W-1:0] INIT = W'(RST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= INIT;
    end else begin
      unique case (step)
        STEP_UP:   if (code != TOP) code <= code + 1'b1;
        STEP_DOWN: if (code != '0)  code <= code - 1'b1;
        default:   code <= code;
      endcase
    end
  end

endmodule

// File: rtl/agc_tip_track.sv
// Sync-tip minimum tracker with white-peak override; one decision per line.
module agc_tip_track
  import agc_pkg::*;
#(
  parameter int DW       = 8,
  parameter int WP_LIMIT = 248
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  input  logic          win,
  input  logic          wpe_en,
  output step_e         step
);

  localparam logic [DW-1:0] LIMIT = DW'(WP_LIMIT);

  logic          win_q;
  logic          seen_q;
  logic          allz_q;
  logic          wp_q;
  logic [DW-1:0] min_q;
  logic          commit;
  logic          accept;
  logic          hot;

  assign commit = win_q & ~win;
  assign accept = s_valid & win;
  assign hot    = s_valid & wpe_en & (s_data > LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= 1'b0;
      seen_q <= 1'b0;
      allz_q <= 1'b0;
      min_q  <= '0;
    end else begin
      win_q <= win;
      if (commit) begin
        seen_q <= 1'b0;
      end else if (accept) begin
        seen_q <= 1'b1;
        if (!seen_q || (s_data < min_q)) min_q <= s_data;
        allz_q <= (seen_q ? allz_q : 1'b1) & (s_data == '0);
      end
    end
  end

  // A hot sample in the closing cycle itself belongs to the next line.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wp_q <= 1'b0;
    else if (commit) wp_q <= hot;
    else if (hot)    wp_q <= 1'b1;
  end

  always_comb begin
    step = STEP_HOLD;
    if (commit) begin
      if (wp_q)                        step = STEP_DOWN;
      else if (seen_q && min_q != '0)  step = STEP_UP;
      else if (seen_q && allz_q)       step = STEP_DOWN;
    end
  end

endmodule

// File: rtl/agc_porch_avg.sv
// Back-porch averager: first 2**AVG_LOG2 samples of the clamp window.
module agc_porch_avg
  import agc_pkg::*;
#(
  parameter int DW       = 8,
  parameter int AVG_LOG2 = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  input  logic          win,
  input  logic [DW-1:0] level_ref,
  output step_e         step
);

  localparam int              CNTW = AVG_LOG2 + 1;
  localparam int              SW   = DW + AVG_LOG2;
  localparam logic [CNTW-1:0] FULL = CNTW'(1 << AVG_LOG2);

  logic            win_q;
  logic [CNTW-1:0] cnt_q;
  logic [SW-1:0]   sum_q;
  logic [DW-1:0]   avg;
  logic            commit;
  logic            accept;

  assign commit = win_q & ~win;
  assign accept = s_valid & win & (cnt_q != FULL);
  assign avg    = sum_q[SW-1 -: DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0;
      cnt_q <= '0;
      sum_q <= '0;
    end else begin
      win_q <= win;
      if (commit) begin
        cnt_q <= '0;
        sum_q <= '0;
      end else if (accept) begin
        cnt_q <= cnt_q + 1'b1;
        sum_q <= sum_q + SW'(s_data);
      end
    end
  end

  always_comb begin
    step = STEP_HOLD;
    if (commit && (cnt_q == FULL)) begin
      if (avg > level_ref)      step = STEP_DOWN;
      else if (avg < level_ref) step = STEP_UP;
    end
  end

endmodule

// File: rtl/agc_sync_tip.sv
// Sync-tip AGC and back-porch clamp loop with optional white-peak limit.
module agc_sync_tip
  import agc_pkg::*;
#(
  parameter int DW       = 8,
  parameter int CW       = 8,
  parameter int WP_LIMIT = 248,
  parameter int AVG_LOG2 = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic          gain_win,
  input  logic          clamp_win,
  input  logic          wpe_en,
  input  logic [DW-1:0] clamp_ref,
  output logic [CW-1:0] gain_code,
  output logic [CW-1:0] offset_code
);

  localparam int MID = 1 << (CW - 1);

  step_e gain_step;
  step_e off_step;

  assign s_ready = 1'b1;

  agc_tip_track #(.DW(DW), .WP_LIMIT(WP_LIMIT)) u_tip (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_valid(s_valid),
    .s_data (s_data),
    .win    (gain_win),
    .wpe_en (wpe_en),
    .step   (gain_step)
  );

  agc_porch_avg #(.DW(DW), .AVG_LOG2(AVG_LOG2)) u_porch (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_valid  (s_valid),
    .s_data   (s_data),
    .win      (clamp_win),
    .level_ref(clamp_ref),
    .step     (off_step)
  );

  agc_step_reg #(.W(CW), .RST(MID)) u_gain (
    .clk  (clk),
    .rst_n(rst_n),
    .step (gain_step),
    .code (gain_code)
  );

  agc_step_reg #(.W(CW), .RST(MID)) u_off (
    .clk  (clk),
    .rst_n(rst_n),
    .step (off_step),
    .code (offset_code)
  );

endmodule

// File: rtl/agc_sync_tip_chk.sv
module agc_sync_tip_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_ready,
  input logic          gain_win,
  input logic          clamp_win,
  input logic [CW-1:0] gain_code,
  input logic [CW-1:0] offset_code
);

  localparam logic [CW-1:0] MID  = CW'(1) << (CW - 1);
  localparam logic [CW-1:0] TOPC = {CW{1'b1}};

  always @(posedge clk) if (rst_n) AST_READY_HIGH: assert (s_ready == 1'b1); // R2

  AST_RESET_MID: assert property (@(posedge clk)
    !rst_n |=> (gain_code == MID) && (offset_code == MID)); // R1

  AST_GAIN_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gain_code) |-> (gain_code == CW'($past(gain_code) + 1'b1)) ||
                            (gain_code == CW'($past(gain_code) - 1'b1))); // R10

  AST_GAIN_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gain_code) |-> !$past(gain_win) && $past(gain_win, 2)); // R10

  AST_GAIN_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gain_code) |-> !($past(gain_code) == TOPC && gain_code == '0) &&
                            !($past(gain_code) == '0 && gain_code == TOPC)); // R7

  AST_OFF_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(offset_code) |-> (offset_code == CW'($past(offset_code) + 1'b1)) ||
                              (offset_code == CW'($past(offset_code) - 1'b1))); // R10

  AST_OFF_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(offset_code) |-> !$past(clamp_win) && $past(clamp_win, 2)); // R10

  AST_OFF_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(offset_code) |-> !($past(offset_code) == TOPC && offset_code == '0) &&
                              !($past(offset_code) == '0 && offset_code == TOPC)); // R9

endmodule

bind agc_sync_tip agc_sync_tip_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .s_ready    (s_ready),
  .gain_win   (gain_win),
  .clamp_win  (clamp_win),
  .gain_code  (gain_code),
  .offset_code(offset_code)
);

// File: tb/agc_sync_tip_tb.sv
`timescale 1ns/1ps
module agc_sync_tip_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_data = '0;
  logic       gain_win = 1'b0;
  logic       clamp_win = 1'b0;
  logic       wpe_en = 1'b0;
  logic [7:0] clamp_ref = '0;
  logic [7:0] gain_code;
  logic [7:0] offset_code;

  int n_chk = 0;
  int n_bad = 0;
  int exp_gain = 128;
  int exp_off = 128;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  agc_sync_tip u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .gain_win(gain_win), .clamp_win(clamp_win),
    .wpe_en(wpe_en), .clamp_ref(clamp_ref),
    .gain_code(gain_code), .offset_code(offset_code)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input int d);
    s_valid = v;
    s_data  = 8'(d);
    @(negedge clk);
  endtask

  // One line: optional pre-window sample, gain window with a bubble, close.
  task automatic gain_line(input int s0, input int s1, input int s2,
                           input int hot, input bit wpe);
    int  mn;
    bit  allz, wp;
    int  nxt;
    string tag;
    wpe_en = wpe;
    gain_win = 1'b0;
    if (hot >= 0) cyc(1'b1, hot); else cyc(1'b0, 0);
    gain_win = 1'b1;
    cyc(1'b1, s0);
    cyc(1'b0, 0);            // idle beat with zero data: must be ignored (R2)
    cyc(1'b1, s1);
    cyc(1'b1, s2);
    check("R10", "gain before close", gain_code, exp_gain);
    gain_win = 1'b0;
    cyc(1'b0, 0);
    mn   = (s0 < s1) ? s0 : s1;
    mn   = (mn < s2) ? mn : s2;
    allz = (s0 == 0) && (s1 == 0) && (s2 == 0);
    wp   = wpe && ((hot > 248) || (s0 > 248) || (s1 > 248) || (s2 > 248));
    nxt  = exp_gain;
    if (wp) begin nxt = exp_gain - 1; tag = "R5"; end
    else if (mn > 0) begin nxt = exp_gain + 1; tag = (hot >= 0) ? "R6" : "R3"; end
    else if (allz) begin nxt = exp_gain - 1; tag = "R4"; end
    else tag = "R4";
    if (nxt > 255) begin nxt = 255; tag = "R7"; end
    if (nxt < 0)   begin nxt = 0;   tag = "R7"; end
    exp_gain = nxt;
    check(tag, "gain_code", gain_code, exp_gain);
    check("R10", "offset during gain line", offset_code, exp_off);
    check("R2", "s_ready", s_ready, 1);
  endtask

  task automatic clamp_line(input int base, input int spread, input int lvl, input int n);
    int sum, used, avg, nxt;
    string tag;
    wpe_en = 1'b0;
    clamp_ref = 8'(lvl);
    clamp_win = 1'b1;
    sum = 0; used = 0;
    for (int k = 0; k < n; k++) begin
      int d = (base + k * spread) % 256;
      cyc(1'b1, d);
      if (k == 0) cyc(1'b0, 255);   // idle beat, ignored
      if (used < 8) begin sum += d; used++; end
    end
    clamp_win = 1'b0;
    cyc(1'b0, 0);
    nxt = exp_off; tag = "R8";
    if (used == 8) begin
      avg = sum >> 3;
      if (avg > lvl) nxt = exp_off - 1;
      else if (avg < lvl) nxt = exp_off + 1;
    end
    if (nxt > 255) begin nxt = 255; tag = "R9"; end
    if (nxt < 0)   begin nxt = 0;   tag = "R9"; end
    exp_off = nxt;
    check(tag, "offset_code", offset_code, exp_off);
    check("R10", "gain during clamp line", gain_code, exp_gain);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "gain in reset", gain_code, 128);
    check("R1", "offset in reset", offset_code, 128);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "gain after reset", gain_code, 128);
    check("R1", "offset after reset", offset_code, 128);
    check("R2", "s_ready", s_ready, 1);

    for (int i = 0; i < 150; i++) gain_line(10, 20, 30, -1, 1'b0);      // R3 up to rail R7
    for (int i = 0; i < 150; i++) gain_line(5, 6, 7, 250, 1'b1);        // R5 priority
    for (int i = 0; i < 300; i++) gain_line(0, 0, 0, -1, 1'b0);         // R4 down to rail R7
    for (int i = 0; i < 256; i++) begin                                 // mixed sweep R3..R6
      int a = i, b = (i * 37 + 11) % 256, c = (i % 3 == 0) ? 0 : (i * 91) % 256;
      if (i % 4 == 0) begin a = 0; b = 0; c = 0; end
      gain_line(a, b, c, (i % 5 == 0) ? 244 + (i % 12) : -1, i[0]);
    end
    gain_line(9, 9, 9, 248, 1'b1);    // R6 boundary: 248 is not a peak
    gain_line(9, 9, 9, 249, 1'b1);    // R5 boundary
    gain_line(9, 9, 9, 255, 1'b0);    // R6 limiter off

    for (int i = 0; i < 200; i++)                                       // R8 sweep
      clamp_line((i * 53) % 256, i % 5, (i * 29) % 256,
                 (i % 7 == 0) ? 5 : ((i % 7 == 1) ? 10 : 8));
    for (int i = 0; i < 140; i++) clamp_line(255, 0, 0, 8);             // R9 low rail
    for (int i = 0; i < 280; i++) clamp_line(0, 0, 255, 8);             // R9 high rail
    clamp_line(100, 0, 100, 8);                                         // R8 equal holds

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule